// File: doc/BRIEF.md
# Packet FIFO to Audio Word Mover

This block drains one received isochronous OUT packet from a USB endpoint's receive FIFO into the transmit buffer of a serial audio transmitter. It moves one 16-bit word at a time. The transmitter paces the transfer: each data request from it causes exactly one word move, and there are no bursts. When the endpoint reports that a packet has arrived, the block checks the byte count. It then loads a word counter with (bytes/2)-1 and enables itself. On each write that the transmitter accepts, it decrements the counter.

When the counter underflows (a decrement while it holds zero), the block disables itself and sets a sticky completion interrupt in the same step. It then sends a one-clock buffer-release strobe back to the endpoint, because the endpoint does not clear its buffer by itself. A packet whose byte count is odd, zero or above the maximum is not transferred. It raises a sticky error flag, and its buffer is released so that the endpoint is not blocked.

The controller has five named states. `ST_IDLE` waits for a packet. `ST_ARMED` is enabled and waits for a request. `ST_WRITE` presents one word to the transmitter. `ST_RELEASE` issues the release strobe. `ST_SETTLE` waits for the ready flag to fall. The transitions are:
- `ST_IDLE`→`ST_ARMED` on a good packet.
- `ST_IDLE`→`ST_RELEASE` on a bad count.
- `ST_ARMED`→`ST_WRITE` when a request and a FIFO word are both present.
- `ST_WRITE`→`ST_ARMED` on acceptance with words left.
- `ST_WRITE`→`ST_RELEASE` on acceptance at underflow.
- `ST_RELEASE`→`ST_SETTLE` always.
- `ST_SETTLE`→`ST_IDLE` once `pkt_ready` is low.

Top module: `pkt_audio_bridge`

## Requirements
- R1: After reset, `busy`, `irq`, `err`, `buf_release`, `aud_wvalid` and `fifo_rd_pop` are all 0.
- R2: When `pkt_ready` is 1 in `ST_IDLE` and `pkt_bytes` is even, nonzero and at most MAX_BYTES (288), the counter is loaded with `pkt_bytes/2 - 1` and `busy` is 1 from the next cycle.
- R3: While `busy` is 1, each request moves exactly one word, and no word moves without a request.
- R4: Words reach `aud_wdata` in FIFO order and unchanged. A word is popped (`fifo_rd_pop`=1) only when `fifo_rd_valid` is 1.
- R5: The counter decrements on each accepted write. Exactly `pkt_bytes/2` words (load value + 1) are written, ending on counter underflow.
- R6: `irq` rises in the cycle after the last word is accepted, together with `busy` falling. It stays 1 until a `flag_ack` pulse clears it.
- R7: After each packet, `buf_release` is 1 for exactly one clock, starting one cycle after the completion step.
- R8: Requests that arrive while `busy` is 0 are ignored and not queued. A packet started after them moves no word until a new request arrives.
- R9: A request that arrives while a word write is waiting for `aud_wready` is held, and it is served after that write is accepted.
- R10: An odd, zero or over-maximum `pkt_bytes` sets the sticky `err` (cleared by `flag_ack`). No word is popped or written, and `buf_release` still pulses once.
- R11: While `aud_wvalid` is 1 and `aud_wready` is 0, `aud_wvalid` stays 1 and `aud_wdata` stays unchanged.
- R12: After the release, the block waits for `pkt_ready` to fall, then handles the next packet in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_ready | input | 1 | Endpoint holds a received packet |
| pkt_bytes | input | BC_W (10) | Byte count of the held packet |
| fifo_rd_valid | input | 1 | Receive FIFO has a word |
| fifo_rd_data | input | 16 | Word at the FIFO head |
| fifo_rd_pop | output | 1 | Removes the head word |
| aud_req | input | 1 | Transmitter data request (pulse) |
| aud_wdata | output | 16 | Word for the transmit buffer |
| aud_wvalid | output | 1 | Word write pending |
| aud_wready | input | 1 | Transmitter accepts the write |
| busy | output | 1 | Channel enabled |
| irq | output | 1 | Sticky completion interrupt |
| err | output | 1 | Sticky bad-count flag |
| flag_ack | input | 1 | Clears `irq` and `err` |
| buf_release | output | 1 | One-clock endpoint buffer release |

## Verification
The main transfer is run with several packet sizes: a single word, a short packet, the full 288-byte packet, and three illegal counts (odd, zero, over maximum). Together these separate an off-by-one in the counter load, a stop at zero instead of at underflow, and a missing error check. A ramp of word values exposes reordered, dropped or repeated words. The requests are paced so that each one lands in `ST_ARMED`, which shows that the word total follows the counter rather than the FIFO depth. Separate directed patterns cover four cases:
- requests made while the channel is disabled;
- a stalled write that receives a second request;
- a sticky interrupt before and after its acknowledge;
- back-to-back packets that rely on the release handshake.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WRITE,
        ST_RELEASE,
        ST_SETTLE
    } pab_state_e;

endpackage

// File: rtl/pab_word_counter.sv
module pab_word_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    // A decrement while the count is zero is the underflow that ends the packet.
    assign last  = (cnt_q == '0);

    // R5: every non-final decrement lowers the count by exactly one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !last) |=> (count == CNT_W'($past(count) - 1'b1)));

    // R2: a load takes the presented value
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

endmodule

// File: rtl/pab_req_latch.sv
module pab_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req,
    input  logic consume,
    output logic have_req
);

    logic pend_q;

    // A request is kept only while the channel is enabled; a move consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!enable || consume) begin
            pend_q <= 1'b0;
        end else if (req) begin
            pend_q <= 1'b1;
        end
    end

    assign have_req = pend_q || (req && enable);

    // R8: nothing stays pending across a disabled cycle
    p_no_pend_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend_q);

    // R9: a request that is not consumed while enabled is still pending next cycle
    p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && req && !consume) |=> pend_q);

endmodule

// File: rtl/pab_ctrl.sv
module pab_ctrl
    import pab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_ready,
    input  logic bytes_ok,
    input  logic fifo_valid,
    input  logic have_req,
    input  logic wready,
    input  logic last,
    output logic load,
    output logic move,
    output logic dec,
    output logic done_set,
    output logic err_set,
    output logic enabled,
    output logic wvalid,
    output logic release_o
);

    pab_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pkt_ready) begin
                    state_d = bytes_ok ? ST_ARMED : ST_RELEASE;
                end
            end
            ST_ARMED: begin
                if (have_req && fifo_valid) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wready) begin
                    state_d = last ? ST_RELEASE : ST_ARMED;
                end
            end
            ST_RELEASE: state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!pkt_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        move      = 1'b0;
        dec       = 1'b0;
        done_set  = 1'b0;
        err_set   = 1'b0;
        enabled   = 1'b0;
        wvalid    = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load    = pkt_ready && bytes_ok;
                err_set = pkt_ready && !bytes_ok;
            end
            ST_ARMED: begin
                enabled = 1'b1;
                move    = have_req && fifo_valid;
            end
            ST_WRITE: begin
                enabled  = 1'b1;
                wvalid   = 1'b1;
                dec      = wready;
                done_set = wready && last;
            end
            ST_RELEASE: release_o = 1'b1;
            ST_SETTLE: ;
            default: ;
        endcase
    end

    // R4: a pop only happens with a word at the FIFO head
    p_pop_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        move |-> fifo_valid);

    // R7: the release strobe lasts one clock
    p_release_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);

    // R6: the channel is disabled in the step that completes the packet
    p_disable_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> (!enabled && release_o));

    // R12: a new packet is not started while the previous one is still flagged
    p_settle_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && pkt_ready) |=> (state_q == ST_SETTLE));

endmodule

// File: rtl/pkt_audio_bridge.sv
module pkt_audio_bridge #(
    parameter int MAX_BYTES = 288,
    parameter int BC_W      = 10,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_ready,
    input  logic [BC_W-1:0]   pkt_bytes,
    input  logic              fifo_rd_valid,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_rd_pop,
    input  logic              aud_req,
    output logic [DATA_W-1:0] aud_wdata,
    output logic              aud_wvalid,
    input  logic              aud_wready,
    output logic              busy,
    output logic              irq,
    output logic              err,
    input  logic              flag_ack,
    output logic              buf_release
);

    localparam int WORDS_MAX = MAX_BYTES / 2;
    localparam int CNT_W     = (WORDS_MAX > 1) ? $clog2(WORDS_MAX) : 1;

    logic              bytes_ok;
    logic [BC_W-1:0]   half_m1;
    logic              load, move, dec, done_set, err_set;
    logic              enabled, wvalid, release_s;
    logic              have_req, last;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] word_q;
    logic              irq_q, err_q;

    // Legal counts are even, nonzero and within the endpoint's maximum packet.
    assign bytes_ok = (pkt_bytes != '0) && !pkt_bytes[0]
                      && (pkt_bytes <= BC_W'(MAX_BYTES));
    assign half_m1  = (pkt_bytes >> 1) - 1'b1;

    pab_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_ready  (pkt_ready),
        .bytes_ok   (bytes_ok),
        .fifo_valid (fifo_rd_valid),
        .have_req   (have_req),
        .wready     (aud_wready),
        .last       (last),
        .load       (load),
        .move       (move),
        .dec        (dec),
        .done_set   (done_set),
        .err_set    (err_set),
        .enabled    (enabled),
        .wvalid     (wvalid),
        .release_o  (release_s)
    );

    pab_req_latch u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enabled),
        .req      (aud_req),
        .consume  (move),
        .have_req (have_req)
    );

    pab_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (half_m1[CNT_W-1:0]),
        .dec      (dec),
        .last     (last),
        .count    (count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (move) begin
            word_q <= fifo_rd_data;
        end
    end

    // Setting a flag takes priority over a simultaneous acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (done_set)      irq_q <= 1'b1;
            else if (flag_ack) irq_q <= 1'b0;
            if (err_set)       err_q <= 1'b1;
            else if (flag_ack) err_q <= 1'b0;
        end
    end

    assign fifo_rd_pop = move;
    assign aud_wdata   = word_q;
    assign aud_wvalid  = wvalid;
    assign busy        = enabled;
    assign irq         = irq_q;
    assign err         = err_q;
    assign buf_release = release_s;

    // R11: a stalled write keeps its word
    p_wvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_wvalid && !aud_wready) |=> (aud_wvalid && $stable(aud_wdata)));

    // R6: the interrupt rises only right after an accepted final write
    p_irq_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(aud_wvalid && aud_wready) && !busy));

    // R10: a bad count never enables the channel and still releases the buffer
    p_err_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && buf_release));

    // R5: the channel stays enabled while the counter has words left
    p_no_early_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (aud_wvalid && aud_wready && count != '0) |=> busy);

endmodule

// File: tb/sim_pkt_audio_bridge.sv
module sim_pkt_audio_bridge;

    localparam int PERIOD = 10;
    localparam int VEC_N  = 6;
    localparam logic [9:0] VEC_BYTES [VEC_N] = '{10'd288, 10'd2, 10'd10, 10'd7, 10'd0, 10'd290};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_ready = 1'b0;
    logic [9:0]  pkt_bytes = '0;
    logic        fifo_rd_valid;
    logic [15:0] fifo_rd_data;
    logic        fifo_rd_pop;
    logic        aud_req = 1'b0;
    logic [15:0] aud_wdata;
    logic        aud_wvalid;
    logic        aud_wready = 1'b1;
    logic        busy, irq, err;
    logic        flag_ack = 1'b0;
    logic        buf_release;

    int tests = 0;
    int fails = 0;

    // FIFO and transmitter model
    logic [15:0] base = 16'h1000;
    int fifo_len = 0;
    int fidx = 0;
    int nrx = 0;
    int mism = 0;
    int cyc = 0;
    int last_acc = -1;
    logic clr = 1'b0;

    function automatic logic [15:0] word_at(input logic [15:0] b, input int i);
        return b + 16'(i * 16'h0103);
    endfunction

    assign fifo_rd_valid = (fidx < fifo_len);
    assign fifo_rd_data  = word_at(base, fidx);

    always #(PERIOD/2) clk = ~clk;

    pkt_audio_bridge u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_ready     (pkt_ready),
        .pkt_bytes     (pkt_bytes),
        .fifo_rd_valid (fifo_rd_valid),
        .fifo_rd_data  (fifo_rd_data),
        .fifo_rd_pop   (fifo_rd_pop),
        .aud_req       (aud_req),
        .aud_wdata     (aud_wdata),
        .aud_wvalid    (aud_wvalid),
        .aud_wready    (aud_wready),
        .busy          (busy),
        .irq           (irq),
        .err           (err),
        .flag_ack      (flag_ack),
        .buf_release   (buf_release)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            fidx <= 0;
            nrx = 0;
            mism = 0;
            last_acc = -1;
        end else begin
            if (fifo_rd_pop) fidx <= fidx + 1;
            if (aud_wvalid && aud_wready) begin
                if (aud_wdata !== word_at(base, nrx)) mism = mism + 1;
                nrx = nrx + 1;
                last_acc = cyc;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_counts();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic ack_flags();
        flag_ack = 1'b1;
        step();
        flag_ack = 1'b0;
    endtask

    // Runs one packet with a request every third cycle; the endpoint model
    // drops pkt_ready when it sees the release strobe.
    task automatic run_packet(input logic [9:0] nbytes, output int rel_n, output int irq_cyc,
                              output int dbl_rel, output int saw_pop_err);
        int after;
        logic prev_rel;
        rel_n = 0; irq_cyc = -1; dbl_rel = 0; saw_pop_err = 0; after = 0; prev_rel = 1'b0;
        clear_counts();
        fifo_len  = int'(nbytes) / 2;
        pkt_bytes = nbytes;
        pkt_ready = 1'b1;
        for (int k = 0; k < 3000 && after < 6; k++) begin
            step();
            if (irq && irq_cyc < 0) irq_cyc = cyc;
            if (buf_release) begin
                rel_n++;
                if (prev_rel) dbl_rel++;
                pkt_ready = 1'b0;
            end
            prev_rel = buf_release;
            if (err && fifo_rd_pop) saw_pop_err++;
            if (rel_n > 0) after++;
            aud_req = (k % 3 == 0);
        end
        aud_req = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rel_n, irq_cyc, dbl, pe, exp_words, exp_err;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 irq/err", {irq, err}, 0);
        check("R1 release/wvalid/pop", {buf_release, aud_wvalid, fifo_rd_pop}, 0);

        // Vector table: packets of varied size, back to back
        for (int v = 0; v < VEC_N; v++) begin
            base = 16'h1000 + 16'(v * 16'h0211);
            exp_err   = (VEC_BYTES[v] == 0 || VEC_BYTES[v][0] || VEC_BYTES[v] > 288) ? 1 : 0;
            exp_words = exp_err ? 0 : int'(VEC_BYTES[v]) / 2;
            run_packet(VEC_BYTES[v], rel_n, irq_cyc, dbl, pe);
            check("R5 word total", nrx, exp_words);
            check("R4 word order", mism, 0);
            check("R10 err flag", err, exp_err);
            check("R6 irq flag", irq, 1 - exp_err);
            check("R7 one release pulse", rel_n, 1);
            check("R7 release width", dbl, 0);
            if (exp_err) begin
                check("R10 no pop", fidx, 0);
            end else begin
                check("R6 irq timing", irq_cyc, last_acc + 1);
                check("R12 packet drained", fidx, exp_words);
            end
            ack_flags();
            check("R6 R10 flags cleared by ack", {irq, err}, 0);
        end

        // R8: requests while disabled are ignored and not queued
        clear_counts();
        base = 16'h4000;
        fifo_len = 3;
        for (int k = 0; k < 5; k++) begin
            aud_req = 1'b1; step(); aud_req = 1'b0; step();
        end
        check("R8 no word while disabled", nrx, 0);
        check("R8 idle", busy, 0);
        pkt_bytes = 10'd6;
        pkt_ready = 1'b1;
        repeat (8) step();
        check("R2 enabled after packet", busy, 1);
        check("R8 stale requests not queued", nrx, 0);

        // R3: one request, one word
        aud_req = 1'b1; step(); aud_req = 1'b0;
        repeat (5) step();
        check("R3 single word per request", nrx, 1);

        // R9/R11: stalled write with a second request held behind it
        aud_wready = 1'b0;
        aud_req = 1'b1; step(); aud_req = 1'b0;
        step();
        aud_req = 1'b1; step(); aud_req = 1'b0;
        repeat (3) step();
        check("R11 wvalid held in stall", aud_wvalid, 1);
        check("R11 data held in stall", int'(aud_wdata), int'(word_at(base, 1)));
        aud_wready = 1'b1;
        repeat (6) step();
        check("R9 held request served", nrx, 3);
        check("R4 directed order", mism, 0);
        check("R6 irq after last word", irq, 1);
        pkt_ready = 1'b0;
        repeat (10) step();
        check("R6 irq sticky", irq, 1);
        ack_flags();
        check("R6 irq cleared", irq, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule